// File: doc/BRIEF.md
# DAC Code Write Synchronizer

This block sits between a processor's register write port and the control register of a multiplying DAC. Each control write carries a code in one of three number formats: offset binary, two's complement or sign-and-magnitude. It also carries a gain-range bit. The block turns the code into the signed-magnitude field that the converter decodes, clamps codes that lie outside the symmetric range, and maps a negative zero to a positive zero.

A control write normally lands in the register on the next clock. Software can instead arm synchronization by writing a one into bit 0 of a separate sync register. The next control write is then tied to the converter's update clock, which is marked by a one-cycle `upd_tick` pulse at the start of each update cycle. If the update clock is already active, the write lands at once. If it is not, the block raises `stall` to hold the processor until the next tick, and then commits the write. A synchronized write uses up the active update clock, which stays inactive until the next tick. It also clears the arm, so each arm covers exactly one write.

Top module: `dac_write_sync`

## Requirements
- R1: After reset `ctrl_reg` reads 0x00, meaning positive sign, zero magnitude and gain 1, and `stall` is low.
- R2: When synchronization is not armed, a control write sets `ctrl_reg` at the next rising edge and `stall` stays low.
- R3: A sync write with `sync_arm` = 1 arms synchronization for the next control write. A sync write with `sync_arm` = 0 changes nothing, and the following write behaves as in R2.
- R4: The update clock is active once a tick has been seen and no synchronized write has consumed it since. An armed write that arrives while the clock is active, or together with a tick, commits at the next edge with no stall.
- R5: An armed write that arrives while the update clock is inactive raises `stall` from the next edge. `stall` holds and `ctrl_reg` keeps its old value until the edge that samples a tick. At that edge the captured value is written and `stall` falls.
- R6: A completed synchronized write clears both the arm and the update clock. The next write is then blind, and a newly armed write stalls until a fresh tick arrives.
- R7: While `stall` is high, control writes and sync writes are ignored, and only the captured write is committed.
- R8: With `wr_fmt` = 0 (offset binary) the value is the code minus 31. Codes above 62 clamp to +31.
- R9: With `wr_fmt` = 1 (two's complement, 8-bit) the code is read as signed. Values below -31 clamp to -31, and values above +31 clamp to +31.
- R10: With `wr_fmt` = 2 or 3 (sign-and-magnitude) bit 5 is the sign (1 = negative), bits 4:0 are the magnitude, and bits 7:6 are ignored.
- R11: A zero magnitude is always stored with sign bit 0, in every format.
- R12: The layout of `ctrl_reg` is: bit 7 the range bit (0 = gain 1, 1 = gain 2), bit 6 always 0, bit 5 the sign, bits 4:0 the magnitude.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Control write strobe |
| wr_code | input | 8 | Code to write |
| wr_fmt | input | 2 | Format of the code: 0 offset binary, 1 two's complement, 2 or 3 sign-and-magnitude |
| wr_range | input | 1 | Gain range bit to write |
| sync_wr | input | 1 | Sync register write strobe |
| sync_arm | input | 1 | Bit 0 of the sync register write data |
| upd_tick | input | 1 | One-cycle pulse at the start of each update cycle |
| stall | output | 1 | Holds the processor while an armed write waits |
| ctrl_reg | output | 8 | DAC control register |

## Verification
Every result is registered, so the effect of a write or a tick sampled at one rising edge is visible in `ctrl_reg` and `stall` right after that edge. The bench drives inputs on falling edges. At every following falling edge it compares both outputs with a behavioural model that applies the same edge's inputs. A stalled write is due at the first edge that samples a tick. The bench therefore checks that `ctrl_reg` holds its old value on every stalled cycle and changes only after the tick. The conversions are checked with hand-computed constants, and the model checks them again on a long random sequence of writes, arms and ticks.

// File: rtl/dac_ws_pkg.sv
package dac_ws_pkg;

  typedef enum logic [1:0] {
    FMT_OFFSET = 2'd0,
    FMT_TWOS   = 2'd1,
    FMT_SIGNM  = 2'd2,
    FMT_SIGNM2 = 2'd3
  } code_fmt_e;

  // Symmetric saturation of a signed value to +/- lim
  function automatic int clamp_sym(input int v, input int lim);
    int r;
    r = v;
    if (r > lim) r = lim;
    if (r < -lim) r = -lim;
    return r;
  endfunction

  // Absolute value as an unsigned 32-bit vector
  function automatic logic [31:0] abs_u32(input int v);
    logic [31:0] r;
    if (v < 0) r = 32'(-v);
    else r = 32'(v);
    return r;
  endfunction

endpackage

// File: rtl/dac_code_conv.sv
module dac_code_conv
  import dac_ws_pkg::*;
#(
  parameter int CODE_W = 8,
  parameter int MAG_W  = 5
) (
  input  logic [CODE_W-1:0] code,
  input  logic [1:0]        fmt,
  output logic              sign,
  output logic [MAG_W-1:0]  mag
);
  localparam int LIM = (1 << MAG_W) - 1;

  int          val_raw;
  int          val_sat;
  logic [31:0] val_abs;
  code_fmt_e   fmt_e;

  always_comb begin
    fmt_e = code_fmt_e'(fmt);
    case (fmt_e)
      FMT_OFFSET: val_raw = int'(code) - LIM;
      FMT_TWOS:   val_raw = int'($signed(code));
      default: begin
        if (code[MAG_W]) val_raw = -int'(code[MAG_W-1:0]);
        else val_raw = int'(code[MAG_W-1:0]);
      end
    endcase
    val_sat = clamp_sym(val_raw, LIM);
    val_abs = abs_u32(val_sat);
    mag     = val_abs[MAG_W-1:0];
    // zero is always stored positive
    sign    = (val_sat < 0);
  end

endmodule

// File: rtl/dac_sync_ctrl.sv
module dac_sync_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_en,
  input  logic sync_wr,
  input  logic sync_arm,
  input  logic upd_tick,
  output logic ld_direct,
  output logic ld_pend,
  output logic capture,
  output logic sync_done,
  output logic stall,
  output logic armed_q,
  output logic active_q
);
  logic pend_q;
  logic active_now;
  logic accept;
  logic arm_set;

  assign active_now = active_q | upd_tick;
  assign accept     = wr_en & ~pend_q;
  assign arm_set    = sync_wr & sync_arm & ~pend_q;

  logic blind;
  logic sync_direct;
  assign blind       = accept & ~armed_q;
  assign sync_direct = accept & armed_q & active_now;
  assign capture     = accept & armed_q & ~active_now;
  assign ld_pend     = pend_q & upd_tick;
  assign ld_direct   = blind | sync_direct;
  assign sync_done   = sync_direct | ld_pend;
  assign stall       = pend_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed_q  <= 1'b0;
      active_q <= 1'b0;
      pend_q   <= 1'b0;
    end else begin
      if (arm_set) armed_q <= 1'b1;
      else if (sync_done) armed_q <= 1'b0;

      if (sync_done) active_q <= 1'b0;
      else if (upd_tick) active_q <= 1'b1;

      if (capture) pend_q <= 1'b1;
      else if (ld_pend) pend_q <= 1'b0;
    end
  end

endmodule

// File: rtl/dac_ctrl_reg.sv
module dac_ctrl_reg #(
  parameter int MAG_W = 5,
  localparam int CTRL_W = MAG_W + 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_direct,
  input  logic              ld_pend,
  input  logic              capture,
  input  logic              range_in,
  input  logic              sign_in,
  input  logic [MAG_W-1:0]  mag_in,
  output logic [CTRL_W-1:0] ctrl_q
);
  logic [CTRL_W-1:0] next_word;
  logic [CTRL_W-1:0] pend_word_q;

  assign next_word = {range_in, 1'b0, sign_in, mag_in};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q      <= '0;
      pend_word_q <= '0;
    end else begin
      if (capture) pend_word_q <= next_word;
      if (ld_pend) ctrl_q <= pend_word_q;
      else if (ld_direct) ctrl_q <= next_word;
    end
  end

endmodule

// File: rtl/dac_write_sync.sv
module dac_write_sync #(
  parameter int CODE_W = 8,
  parameter int MAG_W  = 5,
  localparam int CTRL_W = MAG_W + 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [CODE_W-1:0] wr_code,
  input  logic [1:0]        wr_fmt,
  input  logic              wr_range,
  input  logic              sync_wr,
  input  logic              sync_arm,
  input  logic              upd_tick,
  output logic              stall,
  output logic [CTRL_W-1:0] ctrl_reg
);
  logic             cv_sign;
  logic [MAG_W-1:0] cv_mag;
  logic             ev_ld_direct;
  logic             ev_ld_pend;
  logic             ev_capture;
  logic             ev_sync_done;
  logic             st_armed;
  logic             st_active;

  dac_code_conv #(.CODE_W(CODE_W), .MAG_W(MAG_W)) u_conv (
    .code (wr_code),
    .fmt  (wr_fmt),
    .sign (cv_sign),
    .mag  (cv_mag)
  );

  dac_sync_ctrl u_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .sync_wr   (sync_wr),
    .sync_arm  (sync_arm),
    .upd_tick  (upd_tick),
    .ld_direct (ev_ld_direct),
    .ld_pend   (ev_ld_pend),
    .capture   (ev_capture),
    .sync_done (ev_sync_done),
    .stall     (stall),
    .armed_q   (st_armed),
    .active_q  (st_active)
  );

  dac_ctrl_reg #(.MAG_W(MAG_W)) u_reg (
    .clk       (clk),
    .rst_n     (rst_n),
    .ld_direct (ev_ld_direct),
    .ld_pend   (ev_ld_pend),
    .capture   (ev_capture),
    .range_in  (wr_range),
    .sign_in   (cv_sign),
    .mag_in    (cv_mag),
    .ctrl_q    (ctrl_reg)
  );

endmodule

// File: rtl/dac_write_sync_chk.sv
module dac_write_sync_chk #(
  parameter int CTRL_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic              sync_wr,
  input logic              sync_arm,
  input logic              upd_tick,
  input logic              stall,
  input logic [CTRL_W-1:0] ctrl_reg,
  input logic              ld_direct,
  input logic              capture,
  input logic              sync_done,
  input logic              armed_q,
  input logic              active_q
);
  localparam int MAG_W = CTRL_W - 3;

  // R5
  stall_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stall) |-> $past(wr_en) && $past(armed_q));

  // R5
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stall && !upd_tick |=> stall && $stable(ctrl_reg));

  // R5
  stall_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stall && upd_tick |=> !stall);

  // R6
  clock_consumed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sync_done |=> !active_q);

  // R2
  blind_no_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ld_direct |=> !stall);

  // R3
  arm_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sync_wr && sync_arm && !stall |=> armed_q);

  // R7
  stall_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> !capture);

  // R11
  no_neg_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_reg[MAG_W-1:0] == '0 |-> !ctrl_reg[MAG_W]);

  // R12
  fixed_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_reg[CTRL_W-2]);

endmodule

bind dac_write_sync dac_write_sync_chk #(.CTRL_W(CTRL_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .wr_en     (wr_en),
  .sync_wr   (sync_wr),
  .sync_arm  (sync_arm),
  .upd_tick  (upd_tick),
  .stall     (stall),
  .ctrl_reg  (ctrl_reg),
  .ld_direct (ev_ld_direct),
  .capture   (ev_capture),
  .sync_done (ev_sync_done),
  .armed_q   (st_armed),
  .active_q  (st_active)
);

// File: tb/tb_dac_write_sync.sv
`timescale 1ns/1ps
module tb_dac_write_sync;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_code = 8'h00;
  logic [1:0] wr_fmt = 2'd0;
  logic       wr_range = 1'b0;
  logic       sync_wr = 1'b0;
  logic       sync_arm = 1'b0;
  logic       upd_tick = 1'b0;
  logic       stall;
  logic [7:0] ctrl_reg;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  bit model_on = 1'b0;

  always #2.5 clk = ~clk;

  dac_write_sync dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_code(wr_code),
    .wr_fmt(wr_fmt), .wr_range(wr_range), .sync_wr(sync_wr),
    .sync_arm(sync_arm), .upd_tick(upd_tick), .stall(stall),
    .ctrl_reg(ctrl_reg)
  );

  // reference conversion to the low six bits of the register
  function automatic int ref_field(input int code, input int fmt);
    int v;
    if (fmt == 0) v = code - 31;
    else if (fmt == 1) v = (code > 127) ? code - 256 : code;
    else v = ((code / 32) % 2 == 1) ? -(code % 32) : (code % 32);
    if (v > 31) v = 31;
    if (v < -31) v = -31;
    return (v < 0) ? 32 - v : v;
  endfunction

  // behavioural model
  int m_ctrl = 0, m_armed = 0, m_active = 0, m_pend = 0, m_pend_val = 0;
  always @(posedge clk) begin
    int nv;
    int act_now;
    int done_sync;
    if (!rst_n) begin
      m_ctrl = 0; m_armed = 0; m_active = 0; m_pend = 0; m_pend_val = 0;
    end else begin
      nv = (wr_range ? 128 : 0) + ref_field(int'(wr_code), int'(wr_fmt));
      act_now = (m_active != 0 || upd_tick) ? 1 : 0;
      done_sync = 0;
      if (m_pend != 0) begin
        if (upd_tick) begin
          m_ctrl = m_pend_val; m_pend = 0; done_sync = 1;
        end
      end else begin
        if (wr_en) begin
          if (m_armed == 0) m_ctrl = nv;
          else if (act_now != 0) begin m_ctrl = nv; done_sync = 1; end
          else begin m_pend = 1; m_pend_val = nv; end
        end
        if (sync_wr && sync_arm) m_armed = 2; // set wins over clear
      end
      if (done_sync != 0) begin
        m_active = 0;
        if (m_armed != 2) m_armed = 0;
      end else if (upd_tick) m_active = 1;
      if (m_armed == 2) m_armed = 1;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (model_on && rst_n) begin
      chk("R12 model ctrl_reg", int'(ctrl_reg), m_ctrl);
      chk("R5 model stall", int'(stall), m_pend);
    end
  end

  task automatic idle();
    wr_en = 0; sync_wr = 0; sync_arm = 0; upd_tick = 0;
    @(negedge clk);
  endtask

  task automatic cwrite(input int code, input int fmt, input bit rng, input bit tick);
    wr_en = 1; wr_code = 8'(code); wr_fmt = 2'(fmt); wr_range = rng; upd_tick = tick;
    @(negedge clk);
    wr_en = 0; upd_tick = 0;
  endtask

  task automatic arm(input bit b);
    sync_wr = 1; sync_arm = b;
    @(negedge clk);
    sync_wr = 0; sync_arm = 0;
  endtask

  task automatic tick();
    upd_tick = 1;
    @(negedge clk);
    upd_tick = 0;
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 150000);
    failures++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1
    chk("R1 reset ctrl_reg", int'(ctrl_reg), 0);
    chk("R1 reset stall", int'(stall), 0);
    model_on = 1;

    // R8 offset binary
    cwrite(0, 0, 0, 0);   chk("R8 offset 0", int'(ctrl_reg), 8'h3F);
    chk("R2 blind no stall", int'(stall), 0);
    cwrite(62, 0, 0, 0);  chk("R8 offset 62", int'(ctrl_reg), 8'h1F);
    cwrite(31, 0, 0, 0);  chk("R8 offset 31", int'(ctrl_reg), 8'h00);
    cwrite(200, 0, 0, 0); chk("R8 offset clamp", int'(ctrl_reg), 8'h1F);
    // R9 two's complement
    cwrite(8'hFB, 1, 1, 0); chk("R9 twos -5 R12 range", int'(ctrl_reg), 8'hA5);
    cwrite(8'h80, 1, 0, 0); chk("R9 twos clamp low", int'(ctrl_reg), 8'h3F);
    cwrite(40, 1, 0, 0);    chk("R9 twos clamp high", int'(ctrl_reg), 8'h1F);
    // R10 sign-magnitude
    cwrite(8'h25, 2, 0, 0); chk("R10 signmag", int'(ctrl_reg), 8'h25);
    cwrite(8'hC5, 2, 1, 0); chk("R10 high bits ignored", int'(ctrl_reg), 8'h85);
    cwrite(8'h23, 3, 0, 0); chk("R10 fmt3", int'(ctrl_reg), 8'h23);
    // R11 negative zero
    cwrite(8'h20, 2, 0, 0); chk("R11 neg zero", int'(ctrl_reg), 8'h00);

    // R3 arm with bit0 = 0 does nothing
    arm(0);
    cwrite(8'h05, 2, 0, 0);
    chk("R3 unarmed write lands", int'(ctrl_reg), 8'h05);
    chk("R3 unarmed no stall", int'(stall), 0);

    // R5 armed write, clock inactive
    arm(1);
    cwrite(8'h0A, 2, 0, 0);
    chk("R5 stall raised", int'(stall), 1);
    chk("R5 ctrl held", int'(ctrl_reg), 8'h05);
    idle(); idle();
    // R7 writes ignored while stalled
    cwrite(8'h11, 2, 0, 0);
    arm(1);
    chk("R7 ctrl unchanged", int'(ctrl_reg), 8'h05);
    chk("R5 still stalled", int'(stall), 1);
    tick();
    chk("R5 release ctrl", int'(ctrl_reg), 8'h0A);
    chk("R5 release stall", int'(stall), 0);

    // R6 arm cleared: next write is blind
    cwrite(8'h07, 2, 0, 0);
    chk("R6 blind after sync", int'(ctrl_reg), 8'h07);
    chk("R6 blind no stall", int'(stall), 0);
    // R6 clock consumed: newly armed write stalls
    arm(1);
    cwrite(8'h08, 2, 0, 0);
    chk("R6 stall after consume", int'(stall), 1);
    tick();
    chk("R6 released", int'(ctrl_reg), 8'h08);

    // R4 clock active beforehand
    tick();
    arm(1);
    cwrite(8'h09, 2, 1, 0);
    chk("R4 direct ctrl", int'(ctrl_reg), 8'h89);
    chk("R4 direct no stall", int'(stall), 0);
    // R4 tick in same cycle as the write
    arm(1);
    cwrite(8'h0C, 2, 0, 1);
    chk("R4 same-cycle ctrl", int'(ctrl_reg), 8'h0C);
    chk("R4 same-cycle no stall", int'(stall), 0);

    // random traffic against the model
    for (int i = 0; i < 4000; i++) begin
      wr_en    = ($urandom % 100) < 30;
      sync_wr  = ($urandom % 100) < 15;
      sync_arm = ($urandom % 4) != 0;
      upd_tick = ($urandom % 100) < 12;
      wr_code  = 8'($urandom);
      wr_fmt   = 2'($urandom);
      wr_range = 1'($urandom);
      @(negedge clk);
    end
    idle(); idle();
    summary();
  end
endmodule